// File: doc/BRIEF.md
# Replica Slot Locator with Shared Overflow Sets

This block answers one question for a memory controller that keeps second copies of unreliable 8-byte words: given a word address, in which slot does its copy live? It owns only the bookkeeping: tags, valid bits, and a per-set overflow link. The copies themselves are held elsewhere. The slot space is a set-associative primary table indexed by the low address bits, followed by a small pool of overflow sets that all primary sets share.

Two operations exist. A lookup searches the indexed primary set. It moves on to the linked overflow set only when the primary search misses and the set has a link. An insert is issued while the memory is being tested, when a word is found to need a copy. It places the address in the lowest free primary way. When the primary set is full, it places the address in the linked overflow set. If no link exists yet, it claims the next overflow set in round-robin order. That overflow set may already be serving other primary sets, so several primary sets can end up chained to the same one. If no room is left, the insert reports failure and changes nothing.

Top module: `ras_locator`

## Requirements
- R1: After reset `busy` and `done` are low, no address is present, and a lookup in a set with no link misses.
- R2: A lookup that hits in the primary set raises `done` two clock edges after the accepting edge, with `hit`=1 and `slot` = set*WAYS + way. The set is the low SET_BITS address bits.
- R3: An insert of an absent address into a primary set with a free way takes the lowest-numbered invalid way and completes in two edges with `hit`=1 and that slot.
- R4: An insert of an address that is already present returns its existing slot and allocates no second way.
- R5: When an insert finds its primary set full and unlinked, it links the set to an overflow set. Links are handed out round-robin, starting from overflow set 0 after reset and advancing by one per committed link. The entry takes the lowest free way there, the insert completes in four edges, and `slot` = NSETS*WAYS + oset*OWAYS + oway.
- R6: A lookup that consults the overflow set completes in four edges. A lookup that misses in an unlinked set completes in two.
- R7: A primary set may link to an overflow set already used by another set. Entries of both sets then coexist there and are told apart by the full stored address.
- R8: If lookup and insert are requested in the same idle cycle, only the insert is performed. Requests made while `busy` is high are ignored. Each accepted request yields exactly one single-cycle `done` pulse.
- R9: An insert that finds both its primary set and its linked overflow set full ends in four edges with `fail`=1 and `hit`=0. It leaves all entries, links and the round-robin position unchanged.
- R10: A lookup that misses in both a linked primary set and its overflow set ends in four edges with `hit`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_req | input | 1 | Lookup request, taken when idle |
| ins_req | input | 1 | Insert request, taken when idle, wins over lookup |
| req_addr | input | ADDR_W | Word address of the request |
| busy | output | 1 | An accepted request is in progress |
| done | output | 1 | One-cycle completion pulse |
| hit | output | 1 | Address found or placed |
| fail | output | 1 | Insert found no room |
| slot | output | SLOT_W | Replica slot index, valid when hit |

## Verification
The lookup and insert functions collide when both request lines rise in the same idle cycle. The bench provokes this with a fresh address. It expects a single completion that carries the slot newly allocated for that address, and then no further `done` pulse. A second case raises an insert while a lookup is in flight. The bench judges that insert ignored by looking up the same address afterwards and seeing a two-edge miss.

// File: rtl/ras_pkg.sv
`timescale 1ns/1ps
package ras_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRD,
        ST_PCMP,
        ST_ORD,
        ST_OCMP
    } ras_state_e;

    typedef struct packed {
        logic hit;
        logic fail;
    } ras_verdict_t;

    function automatic int prim_slot(input int set_i, input int way_i, input int ways);
        return set_i * ways + way_i;
    endfunction

    function automatic int ovf_slot(input int base, input int oset_i, input int oway_i,
                                    input int oways);
        return base + oset_i * oways + oway_i;
    endfunction

endpackage

// File: rtl/ras_tag_bank.sv
`timescale 1ns/1ps
module ras_tag_bank #(
    parameter int NROWS = 32,
    parameter int WAYS  = 2,
    parameter int TW    = 7
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          rd_en,
    input  logic [$clog2(NROWS)-1:0]      rd_idx,
    output logic [WAYS*TW-1:0]            rd_tags,
    output logic [WAYS-1:0]               rd_vld,
    input  logic                          wr_en,
    input  logic [$clog2(NROWS)-1:0]      wr_idx,
    input  logic [(WAYS>1 ? $clog2(WAYS) : 1)-1:0] wr_way,
    input  logic [TW-1:0]                 wr_tag
);
    logic [TW-1:0]   tag_mem [NROWS][WAYS];
    logic [WAYS-1:0] vld_mem [NROWS];

    always_ff @(posedge clk) begin
        if (wr_en) tag_mem[wr_idx][wr_way] <= wr_tag;
        if (rd_en) begin
            for (int w = 0; w < WAYS; w++) rd_tags[w*TW +: TW] <= tag_mem[rd_idx][w];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < NROWS; r++) vld_mem[r] <= '0;
            rd_vld <= '0;
        end else begin
            if (wr_en) vld_mem[wr_idx][wr_way] <= 1'b1;
            if (rd_en) rd_vld <= vld_mem[rd_idx];
        end
    end

    // R4
    no_clobber_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !vld_mem[wr_idx][wr_way]);

endmodule

// File: rtl/ras_way_scan.sv
`timescale 1ns/1ps
module ras_way_scan #(
    parameter int WAYS = 2,
    parameter int TW   = 7
) (
    input  logic [WAYS*TW-1:0] tags,
    input  logic [WAYS-1:0]    vld,
    input  logic [TW-1:0]      key,
    output logic               hit,
    output logic [(WAYS>1 ? $clog2(WAYS) : 1)-1:0] hit_way,
    output logic               has_free,
    output logic [(WAYS>1 ? $clog2(WAYS) : 1)-1:0] free_way
);
    localparam int WW = (WAYS > 1) ? $clog2(WAYS) : 1;

    always_comb begin
        hit      = 1'b0;
        hit_way  = '0;
        has_free = 1'b0;
        free_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (vld[w] && tags[w*TW +: TW] == key) begin
                hit     = 1'b1;
                hit_way = WW'(w);
            end
            if (!vld[w]) begin
                has_free = 1'b1;
                free_way = WW'(w);
            end
        end
    end

endmodule

// File: rtl/ras_link_tbl.sv
`timescale 1ns/1ps
module ras_link_tbl #(
    parameter int NROWS = 32,
    parameter int PW    = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     rd_en,
    input  logic [$clog2(NROWS)-1:0] rd_idx,
    output logic                     rd_on,
    output logic [PW-1:0]            rd_ptr,
    input  logic                     wr_en,
    input  logic [$clog2(NROWS)-1:0] wr_idx,
    input  logic [PW-1:0]            wr_ptr
);
    logic [NROWS-1:0] on_q;
    logic [PW-1:0]    ptr_mem [NROWS];

    always_ff @(posedge clk) begin
        if (wr_en) ptr_mem[wr_idx] <= wr_ptr;
        if (rd_en) rd_ptr <= ptr_mem[rd_idx];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            on_q  <= '0;
            rd_on <= 1'b0;
        end else begin
            if (wr_en) on_q[wr_idx] <= 1'b1;
            if (rd_en) rd_on <= on_q[rd_idx];
        end
    end

    // R5
    link_once_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !on_q[wr_idx]);

endmodule

// File: rtl/ras_locator.sv
`timescale 1ns/1ps
module ras_locator
    import ras_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int SET_BITS  = 5,
    parameter int WAYS      = 2,
    parameter int OSET_BITS = 4,
    parameter int OWAYS     = 2,
    localparam int NSETS      = 1 << SET_BITS,
    localparam int OSETS      = 1 << OSET_BITS,
    localparam int PRIM_SLOTS = NSETS * WAYS,
    localparam int TOTAL      = PRIM_SLOTS + OSETS * OWAYS,
    localparam int SLOT_W     = $clog2(TOTAL)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_req,
    input  logic              ins_req,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              busy,
    output logic              done,
    output logic              hit,
    output logic              fail,
    output logic [SLOT_W-1:0] slot
);
    localparam int TAG_W = ADDR_W - SET_BITS;
    localparam int WW    = (WAYS > 1) ? $clog2(WAYS) : 1;
    localparam int OWW   = (OWAYS > 1) ? $clog2(OWAYS) : 1;

    ras_state_e           state_q;
    logic [ADDR_W-1:0]    addr_q;
    logic                 ins_q;
    logic [OSET_BITS-1:0] optr_q;
    logic                 newlnk_q;
    logic [OSET_BITS-1:0] rr_q;
    ras_verdict_t         verdict_q;
    logic [SLOT_W-1:0]    slot_q;
    logic                 done_q;

    logic [SET_BITS-1:0]  set_q;
    logic [TAG_W-1:0]     tag_q;
    assign set_q = addr_q[SET_BITS-1:0];
    assign tag_q = addr_q[ADDR_W-1:SET_BITS];

    logic                 accept;
    assign accept = (state_q == ST_IDLE) && (lk_req || ins_req);

    logic [WAYS*TAG_W-1:0]  p_tags;
    logic [WAYS-1:0]        p_vld;
    logic [OWAYS*ADDR_W-1:0] o_tags;
    logic [OWAYS-1:0]       o_vld;
    logic                   l_on;
    logic [OSET_BITS-1:0]   l_ptr;
    logic                   p_hit, p_free, o_hit, o_free;
    logic [WW-1:0]          p_hit_way, p_free_way;
    logic [OWW-1:0]         o_hit_way, o_free_way;
    logic                   p_wr_en, o_wr_en, l_wr_en;

    assign p_wr_en = (state_q == ST_PCMP) && ins_q && !p_hit && p_free;
    assign o_wr_en = (state_q == ST_OCMP) && ins_q && !o_hit && o_free;
    assign l_wr_en = o_wr_en && newlnk_q;

    ras_tag_bank #(.NROWS(NSETS), .WAYS(WAYS), .TW(TAG_W)) u_prim (
        .clk(clk), .rst(rst),
        .rd_en(state_q == ST_PRD), .rd_idx(set_q), .rd_tags(p_tags), .rd_vld(p_vld),
        .wr_en(p_wr_en), .wr_idx(set_q), .wr_way(p_free_way), .wr_tag(tag_q)
    );

    ras_tag_bank #(.NROWS(OSETS), .WAYS(OWAYS), .TW(ADDR_W)) u_ovf (
        .clk(clk), .rst(rst),
        .rd_en(state_q == ST_ORD), .rd_idx(optr_q), .rd_tags(o_tags), .rd_vld(o_vld),
        .wr_en(o_wr_en), .wr_idx(optr_q), .wr_way(o_free_way), .wr_tag(addr_q)
    );

    ras_link_tbl #(.NROWS(NSETS), .PW(OSET_BITS)) u_link (
        .clk(clk), .rst(rst),
        .rd_en(state_q == ST_PRD), .rd_idx(set_q), .rd_on(l_on), .rd_ptr(l_ptr),
        .wr_en(l_wr_en), .wr_idx(set_q), .wr_ptr(optr_q)
    );

    ras_way_scan #(.WAYS(WAYS), .TW(TAG_W)) u_pscan (
        .tags(p_tags), .vld(p_vld), .key(tag_q),
        .hit(p_hit), .hit_way(p_hit_way), .has_free(p_free), .free_way(p_free_way)
    );

    ras_way_scan #(.WAYS(OWAYS), .TW(ADDR_W)) u_oscan (
        .tags(o_tags), .vld(o_vld), .key(addr_q),
        .hit(o_hit), .hit_way(o_hit_way), .has_free(o_free), .free_way(o_free_way)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            addr_q    <= '0;
            ins_q     <= 1'b0;
            optr_q    <= '0;
            newlnk_q  <= 1'b0;
            rr_q      <= '0;
            verdict_q <= '0;
            slot_q    <= '0;
            done_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (accept) begin
                    addr_q  <= req_addr;
                    ins_q   <= ins_req;
                    state_q <= ST_PRD;
                end
                ST_PRD: state_q <= ST_PCMP;
                ST_PCMP: begin
                    if (p_hit || p_wr_en) begin
                        done_q    <= 1'b1;
                        verdict_q <= '{hit: 1'b1, fail: 1'b0};
                        slot_q    <= SLOT_W'(prim_slot(int'(set_q),
                                         int'(p_hit ? p_hit_way : p_free_way), WAYS));
                        state_q   <= ST_IDLE;
                    end else if (l_on) begin
                        optr_q   <= l_ptr;
                        newlnk_q <= 1'b0;
                        state_q  <= ST_ORD;
                    end else if (ins_q) begin
                        optr_q   <= rr_q;
                        newlnk_q <= 1'b1;
                        state_q  <= ST_ORD;
                    end else begin
                        done_q    <= 1'b1;
                        verdict_q <= '{hit: 1'b0, fail: 1'b0};
                        slot_q    <= '0;
                        state_q   <= ST_IDLE;
                    end
                end
                ST_ORD: state_q <= ST_OCMP;
                ST_OCMP: begin
                    done_q  <= 1'b1;
                    state_q <= ST_IDLE;
                    if (o_hit || o_wr_en) begin
                        verdict_q <= '{hit: 1'b1, fail: 1'b0};
                        slot_q    <= SLOT_W'(ovf_slot(PRIM_SLOTS, int'(optr_q),
                                         int'(o_hit ? o_hit_way : o_free_way), OWAYS));
                        if (o_wr_en && newlnk_q) rr_q <= rr_q + 1'b1;
                    end else begin
                        verdict_q <= '{hit: 1'b0, fail: ins_q};
                        slot_q    <= '0;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy = (state_q != ST_IDLE);
    assign done = done_q;
    assign hit  = verdict_q.hit;
    assign fail = verdict_q.fail;
    assign slot = slot_q;

    // R2
    lat_short_chk: assert property (@(posedge clk) disable iff (rst)
        accept |-> ##3 (done || state_q == ST_ORD));

    // R6
    lat_long_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ORD) |-> ##2 done);

    // R8
    single_done_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    fail_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (done && fail) |-> ($stable(rr_q) && !hit));

    // R9
    fail_on_insert_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_OCMP && !ins_q) |=> !fail);

endmodule

// File: tb/test_ras_locator.sv
`timescale 1ns/1ps
module test_ras_locator;
    localparam int AW = 12;
    localparam int SB = 5;
    localparam int NS = 32;
    localparam int OS = 16;
    localparam int SW = 7;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          lk_req = 1'b0;
    logic          ins_req = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          busy, done, hit, fail;
    logic [SW-1:0] slot;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    ras_locator i_ras_locator (
        .clk(clk), .rst(rst), .lk_req(lk_req), .ins_req(ins_req), .req_addr(req_addr),
        .busy(busy), .done(done), .hit(hit), .fail(fail), .slot(slot)
    );

    always #10 clk = ~clk;

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles, expected under 100000", cyc);
            summary();
        end
    end

    task automatic chk(input bit ok, input string r, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", r, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] mk(input int s, input int k);
        return AW'(((k + 1) << SB) | s);
    endfunction

    function automatic int exp_slot(input int s, input int k);
        if (k < 2) return s * 2 + k;
        return NS * 2 + (s % OS) * 2 + (s / OS);
    endfunction

    task automatic op(input bit ins, input bit lk, input logic [AW-1:0] a,
                      output bit h, output bit f, output int sl, output int n);
        @(negedge clk);
        ins_req = ins; lk_req = lk; req_addr = a;
        @(negedge clk);
        ins_req = 0; lk_req = 0;
        n = 0;
        while (!done && n < 20) begin
            @(negedge clk);
            n++;
        end
        h = hit; f = fail; sl = int'(slot);
    endtask

    task automatic quiet(input string r);
        int extra = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (done) extra++;
        end
        chk(extra == 0, r, extra, 0);
    endtask

    task automatic t_reset();
        bit h, f; int sl, n;
        chk(busy == 0, "R1 busy", busy, 0);
        chk(done == 0, "R1 done", done, 0);
        op(0, 1, mk(0, 0), h, f, sl, n);
        chk(h == 0, "R1 empty lookup", h, 0);
        chk(n == 2, "R6 unlinked miss latency", n, 2);
    endtask

    task automatic t_collide();
        bit h, f; int sl, n;
        op(1, 1, mk(0, 0), h, f, sl, n);
        chk(h == 1, "R8 insert wins hit", h, 1);
        chk(sl == 0, "R8 insert wins slot", sl, 0);
        chk(n == 2, "R3 insert latency", n, 2);
        quiet("R8 single done");
    endtask

    task automatic t_busy_ignore();
        bit h, f; int sl, n;
        @(negedge clk);
        lk_req = 1; req_addr = mk(0, 0);
        @(negedge clk);
        lk_req = 0; ins_req = 1; req_addr = mk(0, 1);
        @(negedge clk);
        ins_req = 0;
        n = 1;
        while (!done && n < 20) begin
            @(negedge clk);
            n++;
        end
        chk(hit == 1 && slot == 0, "R8 in-flight lookup result", int'(slot), 0);
        quiet("R8 busy request no done");
        op(0, 1, mk(0, 1), h, f, sl, n);
        chk(h == 0, "R8 busy insert ignored", h, 0);
    endtask

    task automatic t_dup();
        bit h, f; int sl, n;
        op(1, 0, mk(0, 0), h, f, sl, n);
        chk(h == 1 && sl == 0, "R4 duplicate returns slot", sl, 0);
        op(1, 0, mk(0, 1), h, f, sl, n);
        chk(sl == 1, "R4 no second way used", sl, 1);
    endtask

    task automatic t_fill();
        bit h, f; int sl, n;
        for (int s = 0; s < NS; s++) begin
            for (int k = 0; k < 3; k++) begin
                if (s == 0 && k < 2) continue;
                op(1, 0, mk(s, k), h, f, sl, n);
                if (k < 2) begin
                    chk(h && !f && sl == exp_slot(s, k), "R3 primary slot", sl, exp_slot(s, k));
                    chk(n == 2, "R3 latency", n, 2);
                end else if (s < OS) begin
                    chk(h && !f && sl == exp_slot(s, k), "R5 overflow slot", sl, exp_slot(s, k));
                    chk(n == 4, "R5 latency", n, 4);
                end else begin
                    chk(h && !f && sl == exp_slot(s, k), "R7 shared slot", sl, exp_slot(s, k));
                    chk(n == 4, "R7 latency", n, 4);
                end
            end
        end
    endtask

    task automatic t_miss_linked();
        bit h, f; int sl, n;
        op(0, 1, mk(5, 6), h, f, sl, n);
        chk(h == 0, "R10 linked miss", h, 0);
        chk(n == 4, "R10 latency", n, 4);
    endtask

    task automatic t_full();
        bit h, f; int sl, n;
        op(1, 0, mk(9, 4), h, f, sl, n);
        chk(f == 1, "R9 fail flag", f, 1);
        chk(h == 0, "R9 no hit", h, 0);
        chk(n == 4, "R9 latency", n, 4);
        op(0, 1, mk(9, 4), h, f, sl, n);
        chk(h == 0, "R9 failed address absent", h, 0);
    endtask

    task automatic t_verify();
        bit h, f; int sl, n;
        for (int s = 0; s < NS; s++) begin
            for (int k = 0; k < 3; k++) begin
                op(0, 1, mk(s, k), h, f, sl, n);
                if (k < 2) begin
                    chk(h && sl == exp_slot(s, k), "R2 primary lookup", sl, exp_slot(s, k));
                    chk(n == 2, "R2 latency", n, 2);
                end else begin
                    chk(h && sl == exp_slot(s, k), "R7 overflow lookup", sl, exp_slot(s, k));
                    chk(n == 4, "R6 latency", n, 4);
                end
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_collide();
        t_busy_ignore();
        t_dup();
        t_fill();
        t_miss_linked();
        t_full();
        t_verify();
        summary();
    end

endmodule